// File: doc/BRIEF.md
# Accumulator Store Rounding Logic

This block turns a 40-bit signed accumulator value into a 16-bit 1.15 fraction that can be written back to a register or to memory. The stored word comes from accumulator bits 31 down to 16. The lower sixteen bits are either dropped (truncation) or used to round the word. Two rounding styles are offered: conventional rounding, which always pushes an exact half upward, and convergent rounding, which breaks an exact half toward an even result. After rounding, an optional clamp limits the value, including the eight guard bits above bit 31, to the 1.15 range.

Rounding and clamping are combinational. A single-cycle store strobe registers the result together with its destination. In register mode a register write enable pulses for one cycle. In memory mode the block issues a memory write at the address held in a pointer input and returns that pointer advanced by a fixed step, which is two by default. Bus arbitration and the memory itself sit outside the block.

Top module: `acc_store_rounder`

## Requirements
- R1: With rnd_en_i = 0 the stored word is acc_i[31:16] and bits 15..0 have no effect (sat_en_i = 0 or value already inside the 1.15 range).
- R2: With rnd_en_i = 1 and rnd_conv_i = 0 (conventional), the word is acc_i[31:16] plus acc_i[15]: it increments for a low word of 0x8000..0xFFFF and is unchanged for 0x0000..0x7FFF.
- R3: With rnd_en_i = 1 and rnd_conv_i = 1 (convergent), rounding matches R2 except when acc_i[15:0] == 0x8000, where the word increments only if acc_i[16] is 1.
- R4: With sat_en_i = 1, a rounded value above +32767 (taking bits 39..16 as a signed integer) is stored as 0x7FFF, and one below -32768 is stored as 0x8000.
- R5: With sat_en_i = 1, a rounding carry out of 0x7FFF gives 0x7FFF, not 0x8000.
- R6: With sat_en_i = 0, the stored word is the low 16 bits of the rounded 24-bit value, so out-of-range values wrap.
- R7: A store with dst_mem_i = 0 (register mode) gives, one cycle after the strobe edge, reg_we_o = 1 for one cycle, mem_we_o = 0, wdata_o = the word and ptr_next_o = ptr_i unchanged.
- R8: A store with dst_mem_i = 1 (memory mode) gives, one cycle after the strobe edge, mem_we_o = 1 for one cycle, reg_we_o = 0, mem_addr_o = ptr_i and ptr_next_o = ptr_i + 2 modulo 2^16.
- R9: Without a store strobe both write enables are 0 and wdata_o, mem_addr_o and ptr_next_o keep their values.
- R10: Synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_i | input | 40 | Accumulator value, two's complement |
| rnd_en_i | input | 1 | 1 = round, 0 = truncate |
| rnd_conv_i | input | 1 | 0 = conventional, 1 = convergent rounding |
| sat_en_i | input | 1 | 1 = clamp to the 1.15 range |
| dst_mem_i | input | 1 | 0 = register destination, 1 = memory through pointer |
| store_i | input | 1 | Store strobe, one cycle per store |
| ptr_i | input | 16 | Current pointer register value |
| wdata_o | output | 16 | Stored 1.15 word |
| reg_we_o | output | 1 | Register write enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory write address |
| ptr_next_o | output | 16 | Pointer value after the store |

## Verification
The bench builds the block with its default parameters: a 40-bit accumulator, a 16-bit word, 8 guard bits, a 16-bit pointer and a step of two. With these values the tests can reach the exact 0x8000 tie with either value of bit 16, the carry out of 0x7FFF, guard-bit overflow in both directions with the clamp on and off, and the pointer wrapping from 0xFFFF to 0x0001. Negative accumulator values test that rounding and clamping treat the value as signed.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;

    parameter int ACC_W    = 40;   // accumulator width including guard bits
    parameter int WORD_W   = 16;   // stored fraction width
    parameter int LO_W     = 16;   // bits below the stored word
    parameter int ADDR_W   = 16;   // pointer / address width
    parameter int PTR_STEP = 2;    // post-increment for a word write

    typedef enum logic {
        RND_BIASED     = 1'b0,
        RND_CONVERGENT = 1'b1
    } rnd_mode_e;

    typedef enum logic {
        DST_REG = 1'b0,
        DST_MEM = 1'b1
    } dest_e;

    // Rounding controls as one bundle
    typedef struct packed {
        logic      enable;
        rnd_mode_e mode;
        logic      sat;
    } rnd_ctrl_t;

    // Store request handed to the write-back stage
    typedef struct packed {
        logic [WORD_W-1:0] word;
        dest_e             dest;
        logic [ADDR_W-1:0] ptr;
    } wb_req_t;

endpackage

// File: rtl/acc_store_round.sv
// Combinational rounding of the accumulator into a widened signed value
module acc_store_round
    import acc_store_pkg::*;
#(
    parameter int P_ACC_W = ACC_W,
    parameter int P_LO_W  = LO_W
) (
    input  logic [P_ACC_W-1:0]            acc,
    input  rnd_ctrl_t                     ctrl,
    output logic signed [P_ACC_W-P_LO_W:0] rounded
);
    localparam int HI_W = P_ACC_W - P_LO_W;
    localparam int RW   = HI_W + 1;

    logic [HI_W-1:0]     hi;
    logic                half_bit;
    logic                sticky;
    logic                keep_lsb;
    logic                bump;
    logic signed [RW-1:0] hi_ext;

    assign hi       = acc[P_ACC_W-1:P_LO_W];
    assign half_bit = acc[P_LO_W-1];
    assign keep_lsb = acc[P_LO_W];

    generate
        if (P_LO_W >= 2) begin : g_sticky
            assign sticky = |acc[P_LO_W-2:0];
        end else begin : g_nosticky
            assign sticky = 1'b0;
        end
    endgenerate

    // Tie (half set, rest clear) goes up only for biased mode or odd lsb
    always_comb begin
        bump = 1'b0;
        if (ctrl.enable && half_bit) begin
            if (ctrl.mode == RND_BIASED)
                bump = 1'b1;
            else
                bump = sticky | keep_lsb;
        end
    end

    assign hi_ext  = {hi[HI_W-1], hi};
    assign rounded = hi_ext + $signed({{(RW-1){1'b0}}, bump});
endmodule

// File: rtl/acc_store_clamp.sv
// Limits the widened rounded value to the stored word range
module acc_store_clamp
    import acc_store_pkg::*;
#(
    parameter int IN_W     = ACC_W - LO_W + 1,
    parameter int P_WORD_W = WORD_W
) (
    input  logic signed [IN_W-1:0] value,
    input  logic                   sat_en,
    output logic [P_WORD_W-1:0]    word
);
    localparam logic signed [IN_W-1:0] MAX_V =
        {{(IN_W-P_WORD_W+1){1'b0}}, {(P_WORD_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] MIN_V =
        {{(IN_W-P_WORD_W+1){1'b1}}, {(P_WORD_W-1){1'b0}}};
    localparam logic [P_WORD_W-1:0] POS_LIM = {1'b0, {(P_WORD_W-1){1'b1}}};
    localparam logic [P_WORD_W-1:0] NEG_LIM = {1'b1, {(P_WORD_W-1){1'b0}}};

    logic above;
    logic below;

    assign above = value > MAX_V;
    assign below = value < MIN_V;

    always_comb begin
        word = value[P_WORD_W-1:0];
        if (sat_en && above)
            word = POS_LIM;
        else if (sat_en && below)
            word = NEG_LIM;
    end
endmodule

// File: rtl/acc_store_wb.sv
// Registered write-back: data, destination strobes and pointer update
module acc_store_wb
    import acc_store_pkg::*;
#(
    parameter int P_WORD_W   = WORD_W,
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_PTR_STEP = PTR_STEP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                store,
    input  wb_req_t             req,
    output logic [P_WORD_W-1:0] wdata,
    output logic                reg_we,
    output logic                mem_we,
    output logic [P_ADDR_W-1:0] mem_addr,
    output logic [P_ADDR_W-1:0] ptr_next
);
    localparam logic [P_ADDR_W-1:0] STEP_V = P_ADDR_W'(P_PTR_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata    <= '0;
            reg_we   <= 1'b0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            ptr_next <= '0;
        end else begin
            reg_we <= 1'b0;
            mem_we <= 1'b0;
            if (store) begin
                wdata <= req.word;
                if (req.dest == DST_MEM) begin
                    mem_we   <= 1'b1;
                    mem_addr <= req.ptr;
                    ptr_next <= req.ptr + STEP_V;
                end else begin
                    reg_we   <= 1'b1;
                    ptr_next <= req.ptr;
                end
            end
        end
    end
endmodule

// File: rtl/acc_store_rounder.sv
module acc_store_rounder
    import acc_store_pkg::*;
#(
    parameter int P_ACC_W    = ACC_W,
    parameter int P_WORD_W   = WORD_W,
    parameter int P_LO_W     = LO_W,
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_PTR_STEP = PTR_STEP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_ACC_W-1:0]  acc_i,
    input  logic                rnd_en_i,
    input  logic                rnd_conv_i,
    input  logic                sat_en_i,
    input  logic                dst_mem_i,
    input  logic                store_i,
    input  logic [P_ADDR_W-1:0] ptr_i,
    output logic [P_WORD_W-1:0] wdata_o,
    output logic                reg_we_o,
    output logic                mem_we_o,
    output logic [P_ADDR_W-1:0] mem_addr_o,
    output logic [P_ADDR_W-1:0] ptr_next_o
);
    localparam int RW = P_ACC_W - P_LO_W + 1;

    rnd_ctrl_t            ctrl;
    logic signed [RW-1:0] rounded;
    logic [P_WORD_W-1:0]  word;
    wb_req_t              req;

    assign ctrl.enable = rnd_en_i;
    assign ctrl.mode   = rnd_conv_i ? RND_CONVERGENT : RND_BIASED;
    assign ctrl.sat    = sat_en_i;

    acc_store_round #(
        .P_ACC_W (P_ACC_W),
        .P_LO_W  (P_LO_W)
    ) u_round (
        .acc     (acc_i),
        .ctrl    (ctrl),
        .rounded (rounded)
    );

    acc_store_clamp #(
        .IN_W     (RW),
        .P_WORD_W (P_WORD_W)
    ) u_clamp (
        .value  (rounded),
        .sat_en (ctrl.sat),
        .word   (word)
    );

    assign req.word = word;
    assign req.dest = dst_mem_i ? DST_MEM : DST_REG;
    assign req.ptr  = ptr_i;

    acc_store_wb #(
        .P_WORD_W   (P_WORD_W),
        .P_ADDR_W   (P_ADDR_W),
        .P_PTR_STEP (P_PTR_STEP)
    ) u_wb (
        .clk      (clk),
        .rst      (rst),
        .store    (store_i),
        .req      (req),
        .wdata    (wdata_o),
        .reg_we   (reg_we_o),
        .mem_we   (mem_we_o),
        .mem_addr (mem_addr_o),
        .ptr_next (ptr_next_o)
    );
endmodule

// File: rtl/acc_store_rounder_chk.sv
module acc_store_rounder_chk #(
    parameter int P_ACC_W    = 40,
    parameter int P_WORD_W   = 16,
    parameter int P_LO_W     = 16,
    parameter int P_ADDR_W   = 16,
    parameter int P_PTR_STEP = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [P_ACC_W-1:0]  acc_i,
    input logic                sat_en_i,
    input logic                dst_mem_i,
    input logic                store_i,
    input logic [P_ADDR_W-1:0] ptr_i,
    input logic [P_WORD_W-1:0] wdata_o,
    input logic                reg_we_o,
    input logic                mem_we_o,
    input logic [P_ADDR_W-1:0] mem_addr_o,
    input logic [P_ADDR_W-1:0] ptr_next_o
);
    localparam int TOP = P_LO_W + P_WORD_W - 1;   // sign bit of the word
    localparam logic [P_ADDR_W-1:0] STEP_V = P_ADDR_W'(P_PTR_STEP);
    localparam logic [P_WORD_W-1:0] POS_LIM = {1'b0, {(P_WORD_W-1){1'b1}}};
    localparam logic [P_WORD_W-1:0] NEG_LIM = {1'b1, {(P_WORD_W-1){1'b0}}};

    logic guard_pos;
    logic guard_neg;
    assign guard_pos = !acc_i[P_ACC_W-1] && (acc_i[P_ACC_W-1:TOP] != '0);
    assign guard_neg =  acc_i[P_ACC_W-1] && (acc_i[P_ACC_W-1:TOP] != '1);

    // R10
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (!reg_we_o && !mem_we_o && wdata_o == '0 &&
                 mem_addr_o == '0 && ptr_next_o == '0));

    // R7 / R8
    p_one_dest_r7: assert property (@(posedge clk) disable iff (rst)
        !(reg_we_o && mem_we_o));

    p_reg_store_r7: assert property (@(posedge clk) disable iff (rst)
        (store_i && !dst_mem_i) |=> (reg_we_o && !mem_we_o &&
                                      ptr_next_o == $past(ptr_i)));

    p_mem_store_r8: assert property (@(posedge clk) disable iff (rst)
        (store_i && dst_mem_i) |=> (mem_we_o && !reg_we_o &&
                                     mem_addr_o == $past(ptr_i) &&
                                     ptr_next_o == ($past(ptr_i) + STEP_V)));

    // R9
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !store_i |=> (!reg_we_o && !mem_we_o && $stable(wdata_o) &&
                      $stable(mem_addr_o) && $stable(ptr_next_o)));

    // R4
    p_sat_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (store_i && sat_en_i && guard_pos) |=> (wdata_o == POS_LIM));

    p_sat_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (store_i && sat_en_i && guard_neg) |=> (wdata_o == NEG_LIM));
endmodule

bind acc_store_rounder acc_store_rounder_chk #(
    .P_ACC_W    (P_ACC_W),
    .P_WORD_W   (P_WORD_W),
    .P_LO_W     (P_LO_W),
    .P_ADDR_W   (P_ADDR_W),
    .P_PTR_STEP (P_PTR_STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_i      (acc_i),
    .sat_en_i   (sat_en_i),
    .dst_mem_i  (dst_mem_i),
    .store_i    (store_i),
    .ptr_i      (ptr_i),
    .wdata_o    (wdata_o),
    .reg_we_o   (reg_we_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .ptr_next_o (ptr_next_o)
);

// File: tb/acc_store_rounder_tb.sv
`timescale 1ns/1ps
module acc_store_rounder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] acc_i = '0;
    logic        rnd_en_i = 1'b0;
    logic        rnd_conv_i = 1'b0;
    logic        sat_en_i = 1'b0;
    logic        dst_mem_i = 1'b0;
    logic        store_i = 1'b0;
    logic [15:0] ptr_i = '0;
    logic [15:0] wdata_o;
    logic        reg_we_o;
    logic        mem_we_o;
    logic [15:0] mem_addr_o;
    logic [15:0] ptr_next_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    always #2.5 clk = ~clk;

    acc_store_rounder u_dut (
        .clk        (clk),
        .rst        (rst),
        .acc_i      (acc_i),
        .rnd_en_i   (rnd_en_i),
        .rnd_conv_i (rnd_conv_i),
        .sat_en_i   (sat_en_i),
        .dst_mem_i  (dst_mem_i),
        .store_i    (store_i),
        .ptr_i      (ptr_i),
        .wdata_o    (wdata_o),
        .reg_we_o   (reg_we_o),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .ptr_next_o (ptr_next_o)
    );

    typedef struct {
        logic [15:0] w;
        logic        rwe;
        logic        mwe;
        logic [15:0] addr;
        logic [15:0] pn;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] model_addr = '0;
    logic [15:0] last_w = '0;
    logic [15:0] last_addr = '0;
    logic [15:0] last_pn = '0;

    // Reference value from the requirements R1..R6
    function automatic logic [15:0] ref_word(input logic [39:0] a, input bit ren,
                                             input bit conv, input bit sat);
        int  h;
        bit  up;
        h  = int'($signed(a[39:16]));
        up = ren && a[15] && (!conv || (a[14:0] != 0) || a[16]);
        if (up) h = h + 1;
        if (sat && h > 32767)  h = 32767;
        if (sat && h < -32768) h = -32768;
        return h[15:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one store per cycle, pushes the expected outcome
    task automatic do_store(input logic [39:0] a, input bit ren, input bit conv,
                            input bit sat, input bit mem, input logic [15:0] p,
                            input string tag);
        exp_t e;
        @(negedge clk);
        acc_i = a; rnd_en_i = ren; rnd_conv_i = conv; sat_en_i = sat;
        dst_mem_i = mem; ptr_i = p; store_i = 1'b1;
        e.w   = ref_word(a, ren, conv, sat);
        e.rwe = !mem;
        e.mwe = mem;
        if (mem) model_addr = p;
        e.addr = model_addr;
        e.pn   = mem ? p + 16'd2 : p;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            store_i = 1'b0;
            acc_i   = 40'hA5_5A5A_A5A5;   // noise that must not reach outputs
            ptr_i   = 16'h3C3C;
        end
    endtask

    // Monitor: pops the scoreboard one cycle after each strobe edge
    initial begin
        bit was_store;
        forever begin
            @(posedge clk);
            was_store = store_i && !rst;
            @(negedge clk);
            if (mon_on) begin
                if (was_store) begin
                    if (sb_q.size() == 0) begin
                        check("R7/R8 unexpected store", 64'd1, 64'd0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check({e.tag, " data"}, 64'(wdata_o), 64'(e.w));
                        check({e.tag, " R7 reg_we"}, 64'(reg_we_o), 64'(e.rwe));
                        check({e.tag, " R8 mem_we"}, 64'(mem_we_o), 64'(e.mwe));
                        check({e.tag, " R8 addr"}, 64'(mem_addr_o), 64'(e.addr));
                        check({e.tag, " R8 ptr_next"}, 64'(ptr_next_o), 64'(e.pn));
                    end
                end else begin
                    check("R9 idle we", 64'({reg_we_o, mem_we_o}), 64'd0);
                    check("R9 idle hold", {16'd0, wdata_o, mem_addr_o, ptr_next_o},
                          {16'd0, last_w, last_addr, last_pn});
                end
                last_w    = wdata_o;
                last_addr = mem_addr_o;
                last_pn   = ptr_next_o;
            end
        end
    end

    // Watchdog
    initial begin
        #(5ns * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 reset", {15'd0, reg_we_o, mem_we_o, wdata_o, mem_addr_o, ptr_next_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        @(negedge clk);

        // R1 truncation ignores low word
        do_store(40'h00_1234_FFFF, 0, 0, 0, 0, 16'h0010, "R1 trunc");
        do_store(40'hFF_8001_8000, 0, 1, 1, 0, 16'h0010, "R1 trunc neg");
        idle(2);
        // R2 conventional
        do_store(40'h00_1234_8000, 1, 0, 0, 0, 16'h0020, "R2 half up");
        do_store(40'h00_1234_7FFF, 1, 0, 0, 0, 16'h0020, "R2 below half");
        do_store(40'hFF_FFFE_8000, 1, 0, 1, 0, 16'h0020, "R2 negative");
        idle(1);
        // R3 convergent
        do_store(40'h00_1234_8000, 1, 1, 0, 0, 16'h0030, "R3 tie even");
        do_store(40'h00_1235_8000, 1, 1, 0, 0, 16'h0030, "R3 tie odd");
        do_store(40'h00_1234_8001, 1, 1, 0, 0, 16'h0030, "R3 above tie");
        do_store(40'h00_1234_7FFF, 1, 1, 0, 0, 16'h0030, "R3 below tie");
        idle(1);
        // R4 clamp from guard bits
        do_store(40'h01_0000_0000, 0, 0, 1, 1, 16'h1000, "R4 pos clamp");
        do_store(40'hFE_0000_0000, 1, 0, 1, 1, 16'h1002, "R4 neg clamp");
        do_store(40'hFF_7FFF_FFFF, 1, 0, 1, 0, 16'h0040, "R4 neg edge");
        // R5 rounding carry out of 0x7FFF
        do_store(40'h00_7FFF_8000, 1, 0, 1, 0, 16'h0040, "R5 carry sat");
        do_store(40'h00_7FFF_C000, 1, 1, 1, 1, 16'h1004, "R5 carry sat conv");
        // R6 wrap with clamp off
        do_store(40'h00_7FFF_8000, 1, 0, 0, 0, 16'h0050, "R6 carry wrap");
        do_store(40'h01_0000_0000, 0, 0, 0, 1, 16'h1006, "R6 guard wrap");
        do_store(40'hFE_0000_0000, 0, 0, 0, 0, 16'h0050, "R6 neg wrap");
        idle(2);
        // R7 / R8 destinations, pointer wrap
        do_store(40'h00_4000_0000, 0, 0, 0, 0, 16'h0055, "R7 reg dest");
        do_store(40'h00_4000_0000, 0, 0, 0, 1, 16'hFFFF, "R8 ptr wrap");
        do_store(40'h00_2000_0000, 0, 0, 0, 0, 16'h0123, "R7 addr held");
        do_store(40'h00_2000_0000, 0, 0, 0, 1, 16'hFFFE, "R8 ptr to zero");
        idle(4);

        check("R9 scoreboard drained", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule